// File: doc/BRIEF.md
# Centre-aligned dual-slope PWM generator

This block produces one symmetric pulse-width-modulated output from an up/down counter. A prescaler divides the system clock and sets the rate of the counter ticks. On each tick the counter climbs one step towards its top value (all ones). It then turns and falls one step at a time back to zero, so one full period takes 510 ticks at the default 8-bit width. The output goes low when the count meets the compare threshold on the way up. It goes high when the count meets the threshold on the way down. The high time is therefore centred on the bottom of the triangle, and its length grows in proportion to the threshold.

The threshold can be written at any time. It passes through a shadow register and only reaches the comparator when the counter arrives at its top value, so a period never mixes two thresholds. The two end values give a steady level with no edges at all. An enable input freezes the whole block, and raising the enable restarts the prescaler phase. The output frequency is the clock frequency divided by (divide ratio × 510). With an 8 MHz clock and a ratio of 2, this gives about 7.843 kHz.

Top module: `pwm_phase_correct`

## Requirements
- R1: While enabled, each counter tick moves `count_o` by exactly one: up from 0 to 255, then down from 255 to 0, then up again, with no wrap.
- R2: `dir_down_o` is 0 while the current count was reached by counting up (1 to 255, and 0 after reset), and 1 while it was reached by counting down (254 to 0).
- R3: `presc_sel_i` picks the ticks per system clock: code 0 gives /1, 1 gives /2, 2 gives /8, 3 gives /64, and codes 4 to 7 give /256. One PWM period is 510 ticks.
- R4: For an active threshold k from 1 to 254, the output falls when the count reaches k going up and rises when it reaches k going down. It is high for 2·k ticks per period and has exactly two edges per period.
- R5: An active threshold of 0 keeps the output low, and an active threshold of 255 keeps it high, with no edges in either case.
- R6: `cmp_i` is copied into the active threshold only on the tick at which the count arrives at 255. A value written mid-period leaves the rest of that period unchanged. The active threshold after reset is 255.
- R7: Asynchronous active-low reset sets the count to 0, the direction to up and the output high, and clears the prescaler.
- R8: While `en_i` is low, the count, direction and output hold their values.
- R9: After `en_i` rises, the first counter step occurs exactly N system clocks later, where N is the selected divide ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low freezes the block |
| presc_sel_i | input | 3 | Divide ratio select (see R3) |
| cmp_i | input | CNT_W | Threshold, applied at the next top of count |
| pwm_o | output | 1 | Centre-aligned PWM output |
| count_o | output | CNT_W | Current counter value |
| dir_down_o | output | 1 | 1 when the current count was reached counting down |

## Verification
The assertions assume that reset is applied before the first active clock. Outside of that, every input may change at any clock: the threshold is buffered, and the prescaler compares its count with `>=`, so a change of ratio in mid-count never skips a tick. The edge properties accept an edge at the top of count as well as at a threshold match, because a newly loaded end value can move the output there. The stimulus changes inputs only between clock edges. It keeps the ratio and the threshold steady for a full settling period before each measured window, so each window holds exactly one period under a single active threshold.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  localparam int PS_W = 8;

  typedef enum logic [2:0] {
    PS_DIV1   = 3'd0,
    PS_DIV2   = 3'd1,
    PS_DIV8   = 3'd2,
    PS_DIV64  = 3'd3,
    PS_DIV256 = 3'd4
  } presc_sel_e;

  // last prescaler count before a tick (ratio - 1); codes above 4 map to /256
  function automatic logic [PS_W-1:0] presc_last(input logic [2:0] sel);
    case (presc_sel_e'(sel))
      PS_DIV1:  return PS_W'(0);
      PS_DIV2:  return PS_W'(1);
      PS_DIV8:  return PS_W'(7);
      PS_DIV64: return PS_W'(63);
      default:  return PS_W'(255);
    endcase
  endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [2:0] sel_i,
  output logic       tick_o
);

  logic [PS_W-1:0] div_q;
  logic [PS_W-1:0] last;

  assign last   = presc_last(sel_i);
  // >= keeps a ratio change mid-count from stalling the divider
  assign tick_o = en_i && (div_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              div_q <= '0;
    else if (!en_i || tick_o) div_q <= '0;
    else                      div_q <= div_q + 1'b1;
  end

endmodule

// File: rtl/pwm_updown_counter.sv
module pwm_updown_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             down_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             down_nxt_o
);

  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             down_q;

  always_comb begin
    cnt_nxt_o  = cnt_q;
    down_nxt_o = down_q;
    if (step_i) begin
      if (!down_q) begin
        if (cnt_q == TOP) begin
          down_nxt_o = 1'b1;
          cnt_nxt_o  = cnt_q - 1'b1;
        end else begin
          cnt_nxt_o  = cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q == '0) begin
          down_nxt_o = 1'b0;
          cnt_nxt_o  = cnt_q + 1'b1;
        end else begin
          cnt_nxt_o  = cnt_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt_o;
      down_q <= down_nxt_o;
    end
  end

  assign cnt_o  = cnt_q;
  assign down_o = down_q;

endmodule

// File: rtl/pwm_compare_out.sv
module pwm_compare_out #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic             down_nxt_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             pwm_o,
  output logic [CNT_W-1:0] cmp_act_o
);

  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] k_nxt;
  logic             load;
  logic             level;
  logic             pwm_q;

  // shadow copy taken on arrival at top
  assign load  = step_i && (cnt_nxt_i == TOP) && !down_nxt_i;
  assign k_nxt = load ? cmp_i : cmp_q;

  // level for the state about to be entered: no output latency
  always_comb begin
    if (k_nxt == '0)      level = 1'b0;
    else if (k_nxt == TOP) level = 1'b1;
    else if (down_nxt_i)  level = (cnt_nxt_i <= k_nxt);
    else                  level = (cnt_nxt_i <  k_nxt);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= TOP;
      pwm_q <= 1'b1;
    end else begin
      if (load)   cmp_q <= cmp_i;
      if (step_i) pwm_q <= level;
    end
  end

  assign pwm_o     = pwm_q;
  assign cmp_act_o = cmp_q;

endmodule

// File: rtl/pwm_phase_correct.sv
module pwm_phase_correct #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [2:0]       presc_sel_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             pwm_o,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_down_o
);

  logic             tick;
  logic [CNT_W-1:0] cnt_nxt;
  logic             down_nxt;
  logic [CNT_W-1:0] cmp_act;

  pwm_prescaler u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .sel_i  (presc_sel_i),
    .tick_o (tick)
  );

  pwm_updown_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (tick),
    .cnt_o      (count_o),
    .down_o     (dir_down_o),
    .cnt_nxt_o  (cnt_nxt),
    .down_nxt_o (down_nxt)
  );

  pwm_compare_out #(.CNT_W(CNT_W)) u_cmp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (tick),
    .cnt_nxt_i  (cnt_nxt),
    .down_nxt_i (down_nxt),
    .cmp_i      (cmp_i),
    .pwm_o      (pwm_o),
    .cmp_act_o  (cmp_act)
  );

endmodule

// File: rtl/pwm_phase_correct_chk.sv
module pwm_phase_correct_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [CNT_W-1:0] count_o,
  input logic             dir_down_o,
  input logic             pwm_o,
  input logic [CNT_W-1:0] cmp_act
);

  localparam logic [CNT_W-1:0] TOP = '1;

  assert_unit_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o != $past(count_o)) |->
      (({1'b0, count_o} == {1'b0, $past(count_o)} + 1'b1) ||
       ({1'b0, $past(count_o)} == {1'b0, count_o} + 1'b1)));

  assert_top_is_up_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == TOP) |-> !dir_down_o);

  assert_turn_down_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(count_o) == TOP) && (count_o != TOP)) |-> dir_down_o);

  assert_fall_on_up_match_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwm_o) |-> (!dir_down_o && ((count_o == cmp_act) || (count_o == TOP))));

  assert_rise_on_down_match_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_o) |-> ((dir_down_o && (count_o == cmp_act)) || (count_o == TOP)));

  assert_zero_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_act == '0) |-> !pwm_o);

  assert_full_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_act == TOP) |-> pwm_o);

  assert_load_at_top_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_act != $past(cmp_act)) |-> (count_o == TOP));

  assert_hold_when_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(count_o) && $stable(pwm_o) && $stable(dir_down_o)));

endmodule

bind pwm_phase_correct pwm_phase_correct_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .count_o    (count_o),
  .dir_down_o (dir_down_o),
  .pwm_o      (pwm_o),
  .cmp_act    (cmp_act)
);

// File: tb/pwm_phase_correct_test.sv
module pwm_phase_correct_test;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic [2:0] presc_sel_i = 3'd0;
  logic [7:0] cmp_i = 8'd0;
  logic       pwm_o;
  logic [7:0] count_o;
  logic       dir_down_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  pwm_phase_correct #(.CNT_W(8)) uut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .presc_sel_i (presc_sel_i),
    .cmp_i       (cmp_i),
    .pwm_o       (pwm_o),
    .count_o     (count_o),
    .dir_down_o  (dir_down_o)
  );

  // vector table: select, threshold, ratio, expected high clocks, expected edges
  localparam int NV = 7;
  localparam int V_SEL  [NV] = '{0, 0, 0, 0, 0, 1, 2};
  localparam int V_CMP  [NV] = '{1, 128, 254, 0, 255, 131, 64};
  localparam int V_DIV  [NV] = '{1, 1, 1, 1, 1, 2, 8};
  localparam int V_HIGH [NV] = '{2, 256, 508, 0, 510, 524, 1024};
  localparam int V_EDGE [NV] = '{2, 2, 2, 0, 0, 2, 2};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic wait_at(input int c, input bit d);
    while (!(count_o == 8'(c) && dir_down_o == d)) step();
  endtask

  // advance to the first sample after the count leaves the top
  task automatic leave_top();
    while (count_o != 8'hFF) step();
    while (count_o == 8'hFF) step();
  endtask

  initial begin
    int c0;
    int n, high, edges;
    bit prev, seen_top;

    step();
    step();
    // R7: reset state
    chk(count_o == 8'd0, "R7 count", count_o, 0);
    chk(dir_down_o == 1'b0, "R7 dir", dir_down_o, 0);
    chk(pwm_o == 1'b1, "R7 pwm", pwm_o, 1);
    rst_ni = 1'b1;
    repeat (5) step();
    // R8: disabled after reset holds
    chk(count_o == 8'd0, "R8 hold count", count_o, 0);

    cmp_i = 8'd10;
    presc_sel_i = 3'd0;
    en_i = 1'b1;
    step();
    chk(count_o == 8'd1, "R9 first step /1", count_o, 1);
    wait_at(200, 1'b0);
    chk(pwm_o == 1'b1, "R6 reset threshold 255", pwm_o, 1);
    wait_at(100, 1'b1);
    chk(pwm_o == 1'b0, "R6 threshold loaded at top", pwm_o, 0);

    // R1/R2: triangle shape at /1
    wait_at(0, 1'b1);
    repeat (255) step();
    chk(count_o == 8'd255, "R1 reach top", count_o, 255);
    chk(dir_down_o == 1'b0, "R2 dir at top", dir_down_o, 0);
    step();
    chk(count_o == 8'd254, "R1 turn down", count_o, 254);
    chk(dir_down_o == 1'b1, "R2 dir after top", dir_down_o, 1);
    repeat (254) step();
    chk(count_o == 8'd0, "R1 reach bottom", count_o, 0);
    chk(dir_down_o == 1'b1, "R2 dir at bottom", dir_down_o, 1);
    step();
    chk(count_o == 8'd1, "R1 turn up", count_o, 1);
    chk(dir_down_o == 1'b0, "R2 dir after bottom", dir_down_o, 0);

    // table: R3 period, R4 duty and edges, R5 end values
    for (int i = 0; i < NV; i++) begin
      presc_sel_i = 3'(V_SEL[i]);
      cmp_i = 8'(V_CMP[i]);
      leave_top();
      leave_top();
      n = 0; high = 0; edges = 0; seen_top = 1'b0;
      prev = pwm_o;
      forever begin
        if (pwm_o) high++;
        n++;
        step();
        if (pwm_o != prev) edges++;
        prev = pwm_o;
        if (count_o == 8'hFF) seen_top = 1'b1;
        else if (seen_top) break;
      end
      chk(n == 510 * V_DIV[i], "R3 period clocks", n, 510 * V_DIV[i]);
      chk(high == V_HIGH[i], "R4 R5 high clocks", high, V_HIGH[i]);
      chk(edges == V_EDGE[i], "R4 R5 edges", edges, V_EDGE[i]);
    end

    // R9 and R3: prescaler restart for /64, /256 and an upper code
    for (int j = 0; j < 3; j++) begin
      int sel_v = (j == 0) ? 3 : (j == 1) ? 4 : 7;
      int div_v = (j == 0) ? 64 : 256;
      en_i = 1'b0;
      step();
      presc_sel_i = 3'(sel_v);
      en_i = 1'b1;
      c0 = count_o;
      repeat (div_v - 1) step();
      chk(count_o == 8'(c0), "R9 no step before ratio", count_o, c0);
      step();
      chk(count_o != 8'(c0), "R9 step at ratio", count_o, c0 + 1);
    end

    // R8: enable low freezes outputs
    presc_sel_i = 3'd0;
    cmp_i = 8'd100;
    leave_top();
    wait_at(90, 1'b1);
    en_i = 1'b0;
    step();
    c0 = count_o;
    prev = pwm_o;
    seen_top = dir_down_o;
    repeat (40) step();
    chk(count_o == 8'(c0), "R8 count held", count_o, c0);
    chk(pwm_o == prev, "R8 pwm held", pwm_o, prev);
    chk(dir_down_o == seen_top, "R8 dir held", dir_down_o, seen_top);
    en_i = 1'b1;

    // R6: mid-period write waits for top
    cmp_i = 8'd128;
    leave_top();
    leave_top();
    wait_at(20, 1'b0);
    cmp_i = 8'd50;
    wait_at(60, 1'b0);
    chk(pwm_o == 1'b1, "R6 old threshold kept up", pwm_o, 1);
    wait_at(130, 1'b0);
    chk(pwm_o == 1'b0, "R6 old match clears", pwm_o, 0);
    wait_at(100, 1'b1);
    chk(pwm_o == 1'b0, "R6 new threshold down", pwm_o, 0);
    wait_at(40, 1'b1);
    chk(pwm_o == 1'b1, "R6 new match sets", pwm_o, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule